// File: doc/BRIEF.md
# Power-Fail Write-Inhibit Sequencer

This block sits between a pair of supply comparators and the control path of a nonvolatile byte-wide memory. It decides, one clock at a time, whether the memory may be used. One flag reports that the supply sits above the full-operation level, the other that it has fallen below the protect level. When the supply sags below the protect level, writes are blocked, the data outputs are forced to high impedance and every control and address input is ignored. The stored contents therefore cannot change while the part is protected or unpowered.

Recovery is not immediate. Once the supply climbs back above the full-operation level, the block keeps the memory locked for a settling window of 20 µs, counted in clock cycles, and only then raises its ready flag. Between the two thresholds the block keeps whatever decision it last made. A live memory stays live, and a locked memory stays locked. This hysteresis keeps a noisy supply from toggling access. There is no data stream through the block, so all pins are plain level signals with no valid/ready handshake and no back-pressure.

Top module: `pfw_sequencer`

## Requirements
- R1: While reset is asserted and right after it, `wr_protect`, `out_hiz` and `in_ignore` are 1 and `ready` is 0.
- R2: In the same cycle that `supply_low` is 1, `wr_protect`, `out_hiz` and `in_ignore` are 1 and `ready` is 0, before any clock edge. The lock then persists after the edge.
- R3: Starting from a locked state, `ready` goes to 1 right after the clock edge that is the SETTLE_CYCLES+1-th consecutive edge with `supply_ok`=1 and `supply_low`=0. It stays 0 before that edge.
- R4: While ready, a supply between the thresholds (`supply_ok`=0, `supply_low`=0) keeps the block ready.
- R5: While locked, a supply between the thresholds keeps the block locked.
- R6: If `supply_low` goes to 1 during the settling window, the block locks. A later recovery needs the full settling window again.
- R7: If `supply_ok` drops to 0 during the settling window, the block returns to the locked state. The window restarts from zero on the next recovery.
- R8: If both flags are 1 at once, the low indication wins and the block locks.
- R9: `ready` is 1 exactly when `wr_protect`, `out_hiz` and `in_ignore` are all 0.
- R10: SETTLE_CYCLES equals CLK_KHZ*SETTLE_US/1000, rounded up. The defaults of 125000 kHz and 20 µs give 2500 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| supply_ok | input | 1 | Supply is above the full-operation level |
| supply_low | input | 1 | Supply is below the protect level |
| wr_protect | output | 1 | Blocks all writes to the array |
| out_hiz | output | 1 | Forces the data outputs to high impedance |
| in_ignore | output | 1 | Marks control and address inputs as don't-care |
| ready | output | 1 | Normal operation is allowed |

## Verification
The bench builds the block with its defaults: a 125000 kHz clock and a 20 µs window, which give a 2500-cycle settling delay. That length lets the bench run the full window several times and compare the cycles on both sides of the release edge. It also lets the bench break the window partway through with a low indication or a lost full-operation flag, and confirm that the next recovery waits the full 2500 cycles again. The combinational lock path is checked within the cycle that the low flag appears, before any edge.

// File: rtl/pfw_pkg.sv
package pfw_pkg;
  typedef enum logic [1:0] {
    ST_DOWN   = 2'd0,  // supply under the protect level
    ST_HOLD   = 2'd1,  // locked, supply not yet at full level
    ST_SETTLE = 2'd2,  // full level reached, waiting out the window
    ST_LIVE   = 2'd3   // normal operation
  } pfw_state_e;

  function automatic int unsigned settle_len(input int unsigned clk_khz,
                                             input int unsigned win_us);
    return (clk_khz * win_us + 999) / 1000;
  endfunction
endpackage

// File: rtl/pfw_settle_timer.sv
module pfw_settle_timer #(
  parameter int unsigned CYCLES = 2500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic done
);
  localparam int unsigned CW = (CYCLES < 2) ? 1 : $clog2(CYCLES);
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q;

  assign done = (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (clear)      cnt_q <= '0;
    else if (run && !done) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pfw_state_ctrl.sv
module pfw_state_ctrl
  import pfw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supply_ok,
  input  logic       supply_low,
  input  logic       win_done,
  output logic       win_clear,
  output logic       win_run,
  output pfw_state_e state
);
  pfw_state_e nxt;
  logic full_up;

  assign full_up   = supply_ok && !supply_low;
  assign win_clear = (state != ST_SETTLE);
  assign win_run   = (state == ST_SETTLE) && full_up;

  always_comb begin
    nxt = state;
    if (supply_low) begin
      nxt = ST_DOWN;
    end else begin
      unique case (state)
        ST_DOWN, ST_HOLD: nxt = supply_ok ? ST_SETTLE : ST_HOLD;
        ST_SETTLE: begin
          if (!supply_ok)    nxt = ST_HOLD;
          else if (win_done) nxt = ST_LIVE;
        end
        ST_LIVE:  nxt = ST_LIVE;
        default:  nxt = ST_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_HOLD;
    else        state <= nxt;
  end
endmodule

// File: rtl/pfw_gate.sv
module pfw_gate
  import pfw_pkg::*;
(
  input  pfw_state_e state,
  input  logic       supply_low,
  output logic       wr_protect,
  output logic       out_hiz,
  output logic       in_ignore,
  output logic       ready
);
  logic live;

  // the low flag bypasses the state register so the lock needs no edge
  assign live       = (state == ST_LIVE) && !supply_low;
  assign ready      = live;
  assign wr_protect = !live;
  assign out_hiz    = !live;
  assign in_ignore  = !live;
endmodule

// File: rtl/pfw_sequencer.sv
module pfw_sequencer
  import pfw_pkg::*;
#(
  parameter int unsigned CLK_KHZ   = 125000,
  parameter int unsigned SETTLE_US = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic supply_low,
  output logic wr_protect,
  output logic out_hiz,
  output logic in_ignore,
  output logic ready
);
  localparam int unsigned SETTLE_CYCLES = settle_len(CLK_KHZ, SETTLE_US);

  pfw_state_e state;
  logic win_clear, win_run, win_done;

  pfw_state_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .supply_ok (supply_ok),
    .supply_low(supply_low),
    .win_done  (win_done),
    .win_clear (win_clear),
    .win_run   (win_run),
    .state     (state)
  );

  pfw_settle_timer #(.CYCLES(SETTLE_CYCLES)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .clear(win_clear),
    .run  (win_run),
    .done (win_done)
  );

  pfw_gate u_gate (
    .state     (state),
    .supply_low(supply_low),
    .wr_protect(wr_protect),
    .out_hiz   (out_hiz),
    .in_ignore (in_ignore),
    .ready     (ready)
  );
endmodule

// File: rtl/pfw_sequencer_chk.sv
module pfw_sequencer_chk #(
  parameter int unsigned CLK_KHZ   = 125000,
  parameter int unsigned SETTLE_US = 20
) (
  input logic clk,
  input logic rst_n,
  input logic supply_ok,
  input logic supply_low,
  input logic wr_protect,
  input logic out_hiz,
  input logic in_ignore,
  input logic ready
);
  localparam int unsigned N  = pfw_pkg::settle_len(CLK_KHZ, SETTLE_US);
  localparam int unsigned RW = $clog2(N + 2);
  localparam logic [RW-1:0] CAP = RW'(N + 1);

  logic [RW-1:0] run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         run_q <= '0;
    else if (!(supply_ok && !supply_low)) run_q <= '0;
    else if (run_q != CAP)              run_q <= run_q + 1'b1;
  end

  p_low_locks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    supply_low |-> (wr_protect && out_hiz && in_ignore && !ready));

  p_window_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> (run_q >= RW'(N)));

  p_hold_live_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !supply_low) |=> (ready || supply_low));

  p_hold_lock_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && !supply_ok) |=> !ready);

  p_both_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_ok && supply_low) |-> !ready);

  p_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ready == !(wr_protect || out_hiz || in_ignore));
endmodule

bind pfw_sequencer pfw_sequencer_chk #(
  .CLK_KHZ  (CLK_KHZ),
  .SETTLE_US(SETTLE_US)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .supply_ok (supply_ok),
  .supply_low(supply_low),
  .wr_protect(wr_protect),
  .out_hiz   (out_hiz),
  .in_ignore (in_ignore),
  .ready     (ready)
);

// File: tb/pfw_sequencer_test.sv
module pfw_sequencer_test;
  localparam int N = 2500;  // R10: 125000 kHz * 20 us / 1000
  localparam logic [3:0] LOCK = 4'b1110;  // {wr_protect,out_hiz,in_ignore,ready}
  localparam logic [3:0] LIVE = 4'b0001;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_ok = 1'b0;
  logic supply_low = 1'b0;
  logic wr_protect, out_hiz, in_ignore, ready;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  typedef struct {
    logic [3:0] exp;
    string      tag;
  } item_t;
  item_t sb[$];

  always #4 clk = ~clk;  // 125 MHz

  pfw_sequencer uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .supply_ok (supply_ok),
    .supply_low(supply_low),
    .wr_protect(wr_protect),
    .out_hiz   (out_hiz),
    .in_ignore (in_ignore),
    .ready     (ready)
  );

  function automatic logic [3:0] outs();
    return {wr_protect, out_hiz, in_ignore, ready};
  endfunction

  task automatic compare(input logic [3:0] exp, input string tag);
    n_cmp++;
    if (outs() !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", tag, outs(), exp, $time);
    end
  endtask

  // driver: set inputs for the next edge and queue the post-edge expectation
  task automatic apply(input logic ok, input logic low,
                       input logic [3:0] exp, input string tag);
    @(negedge clk);
    supply_ok  = ok;
    supply_low = low;
    sb.push_back('{exp, tag});
  endtask

  // check the combinational outputs before any edge
  task automatic check_now(input logic [3:0] exp, input string tag);
    #1;
    compare(exp, tag);
  endtask

  task automatic recover(input string tag);
    for (int i = 0; i <= N; i++)
      apply(1'b1, 1'b0, (i == N) ? LIVE : LOCK, tag);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() != 0) begin
        item_t it;
        it = sb.pop_front();
        compare(it.exp, it.tag);
      end
    end
  end

  initial begin
    #(8 * 40000);
    if (!finished) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    #1;
    compare(LOCK, "R1 in reset");
    repeat (3) @(negedge clk);
    compare(LOCK, "R1 held reset");
    rst_n = 1'b1;
    apply(1'b0, 1'b0, LOCK, "R1 after reset");
    for (int i = 0; i < 5; i++) apply(1'b0, 1'b0, LOCK, "R5 mid band locked");

    // R3/R10 full window
    recover("R3 first window");
    for (int i = 0; i < 6; i++) apply(1'b1, 1'b0, LIVE, "R9 live outputs");

    // R4 hysteresis while live
    for (int i = 0; i < 8; i++) apply(1'b0, 1'b0, LIVE, "R4 mid band keeps ready");

    // R2 immediate lock
    @(negedge clk);
    supply_ok = 1'b0;
    supply_low = 1'b1;
    check_now(LOCK, "R2 same cycle lock");
    sb.push_back('{LOCK, "R2 after edge"});
    for (int i = 0; i < 4; i++) apply(1'b0, 1'b1, LOCK, "R2 held low");

    // R5 stays locked between thresholds
    for (int i = 0; i < 8; i++) apply(1'b0, 1'b0, LOCK, "R5 mid band keeps lock");

    // R6 low during the window restarts it
    for (int i = 0; i < 300; i++) apply(1'b1, 1'b0, LOCK, "R6 partial window");
    @(negedge clk);
    supply_low = 1'b1;
    check_now(LOCK, "R6 low in window");
    sb.push_back('{LOCK, "R6 low after edge"});
    recover("R6 full window again");

    // R7 loss of full level during the window
    @(negedge clk);
    supply_low = 1'b1;
    check_now(LOCK, "R2 lock from live");
    sb.push_back('{LOCK, "R2 lock from live edge"});
    for (int i = 0; i < N - 10; i++) apply(1'b1, 1'b0, LOCK, "R7 partial window");
    apply(1'b0, 1'b0, LOCK, "R7 drop to mid band");
    recover("R7 full window again");

    // R8 both flags set
    @(negedge clk);
    supply_ok = 1'b1;
    supply_low = 1'b1;
    check_now(LOCK, "R8 both flags immediate");
    sb.push_back('{LOCK, "R8 both flags edge"});
    for (int i = 0; i < 3; i++) apply(1'b1, 1'b1, LOCK, "R8 both flags held");
    recover("R8 recovery");

    // R1 reset from live
    @(negedge clk);
    rst_n = 1'b0;
    check_now(LOCK, "R1 reset from live");
    @(negedge clk);
    rst_n = 1'b1;
    apply(1'b0, 1'b0, LOCK, "R1 released mid band");

    @(negedge clk);
    @(negedge clk);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule